// File: doc/BRIEF.md
# Machine-Cycle Timing and Fetch Sequencer

This block divides the oscillator clock of an 8-bit controller core into machine cycles. A machine cycle is six states, and each state has a first and a second phase. The block reports the current state and phase and drives the address latch enable pin. It also decides, slot by slot, whether the byte coming from code memory is latched as an opcode, latched as an operand, or thrown away. It says when the program counter may advance, opens the external data strobe window, and pulses once when an instruction finishes.

The decode logic supplies three attributes of the instruction whose opcode has just been latched: whether it is two bytes long, how many machine cycles it takes, and whether it is an external data move. The sequencer samples these attributes once per instruction and runs the instruction's cycles from them. An external data move gives up both code fetches and both address latch pulses of its second cycle to the data access.

Top module: `mcyc_fetch_seq`

## Requirements
- R1: After reset the block steps through 12 oscillator periods per machine cycle and then repeats. `state_o` counts 0 to 5, where 0 is the first state. `phase_o` is 0 in the first half of each state and 1 in the second half.
- R2: `ale_o` is high in two windows of every machine cycle that is not suppressed: state 0 phase 1 together with state 1 phase 0, and state 3 phase 1 together with state 4 phase 0.
- R3: `opc_latch_o` and `pc_inc_o` are high together in state 0 phase 1 of the first cycle of every instruction.
- R4: For a two-byte instruction (`ins_len2_i`=1), `opr_latch_o` and `pc_inc_o` are high together in state 3 phase 1 of the first cycle.
- R5: For a one-byte instruction, `discard_o` is high in state 3 phase 1 of the first cycle and `pc_inc_o` stays low. At most one of the opcode, operand and discard strobes is high at any time.
- R6: An instruction takes `ins_cyc_i` machine cycles. A value of 0 means 1 cycle, and values above MAX_CYC (default 4) mean MAX_CYC cycles. `eoi_o` pulses in state 5 phase 1 of the last cycle only.
- R7: In every cycle after the first, both fetch slots (state 0 phase 1 and state 3 phase 1) raise `discard_o` with `pc_inc_o` low, and no latch strobe is raised.
- R8: When `ins_xdata_i`=1 the instruction is one byte long and takes two cycles, whatever the other inputs say. In its second cycle, `ale_o`, `discard_o` and both latch strobes stay low, and `xdata_stb_o` is high for all 12 periods.
- R9: The attributes are sampled only on the clock edge that ends state 0 phase 1 of the first cycle. Changes at any other time have no effect on the current instruction.
- R10: A synchronous reset (`rst`=1) returns the block to state 0 phase 0 of a new first cycle with every output strobe low, even in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_len2_i | input | 1 | 1 = two-byte instruction |
| ins_cyc_i | input | CYC_W | Machine cycle count of the instruction (0 means 1) |
| ins_xdata_i | input | 1 | 1 = external data move |
| state_o | output | 3 | Current state, 0..5 |
| phase_o | output | 1 | Current phase, 0 = first, 1 = second |
| ale_o | output | 1 | Address latch enable |
| opc_latch_o | output | 1 | Latch the code byte as opcode |
| opr_latch_o | output | 1 | Latch the code byte as operand |
| discard_o | output | 1 | Code byte is fetched and dropped |
| pc_inc_o | output | 1 | Program counter increment enable |
| xdata_stb_o | output | 1 | External data access window |
| eoi_o | output | 1 | Instruction completes this period |

## Verification
Every output is decoded from the slot counter, the cycle index and the captured attributes. A wrong slot count therefore shows at once on `state_o`/`phase_o`, and it shows within one machine cycle on `ale_o` and the fetch strobes. A wrong cycle index or a wrong captured attribute first shows at the next fetch slot, which is at most six periods away, as a wrong strobe choice. It can also show later, at the end of the instruction, as an `eoi_o` that comes too early or too late. The bench checks every output in every period, across all combinations of length, cycle count and data-move flag, and it also checks a reset taken in the middle of a data move.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
   localparam int N_STATES = 6;
   localparam int N_PHASES = 2;
   localparam int N_SLOTS  = N_STATES * N_PHASES;
   localparam int SLOT_W   = $clog2(N_SLOTS);
   localparam int ST_W     = $clog2(N_STATES);

   typedef logic [SLOT_W-1:0] slot_t;

   function automatic slot_t slot_of(input int st, input int ph);
      return slot_t'(st * N_PHASES + ph);
   endfunction

   // fetch slots and latch-enable windows (behavioural positions)
   localparam slot_t SL_FETCH_A = slot_of(0, 1);
   localparam slot_t SL_ALE_A2  = slot_of(1, 0);
   localparam slot_t SL_FETCH_B = slot_of(3, 1);
   localparam slot_t SL_ALE_B2  = slot_of(4, 0);
   localparam slot_t SL_LAST    = slot_of(N_STATES - 1, 1);

   typedef struct packed {
      logic len2;
      logic xdata;
   } attr_t;
endpackage

// File: rtl/mcyc_slot_ctr.sv
module mcyc_slot_ctr
   import mcyc_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
) (
   input  logic  clk,
   input  logic  rst,
   output slot_t slot_o,
   output logic  wrap_o
);
   generate
      if (ONEHOT) begin : g_ring
         logic [N_SLOTS-1:0] ring_q;
         always_ff @(posedge clk) begin
            if (rst) ring_q <= {{(N_SLOTS-1){1'b0}}, 1'b1};
            else     ring_q <= {ring_q[N_SLOTS-2:0], ring_q[N_SLOTS-1]};
         end
         always_comb begin
            slot_o = '0;
            for (int i = 0; i < N_SLOTS; i++)
               if (ring_q[i]) slot_o = slot_o | slot_t'(i);
         end
         assign wrap_o = ring_q[N_SLOTS-1];
      end else begin : g_bin
         slot_t cnt_q;
         always_ff @(posedge clk) begin
            if (rst)                  cnt_q <= '0;
            else if (cnt_q == SL_LAST) cnt_q <= '0;
            else                      cnt_q <= cnt_q + slot_t'(1);
         end
         assign slot_o = cnt_q;
         assign wrap_o = (cnt_q == SL_LAST);
      end
   endgenerate
endmodule

// File: rtl/mcyc_cyc_track.sv
module mcyc_cyc_track
   import mcyc_pkg::*;
#(
   parameter int MAX_CYC = 4,
   parameter int CYC_W   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  slot_t            slot_i,
   input  logic             wrap_i,
   input  logic             len2_i,
   input  logic [CYC_W-1:0] cyc_i,
   input  logic             xdata_i,
   output logic [CYC_W-1:0] cyc_idx_o,
   output attr_t            attr_o,
   output logic             last_o
);
   localparam logic [CYC_W-1:0] CMAX = CYC_W'(MAX_CYC);
   localparam logic [CYC_W-1:0] ONE  = CYC_W'(1);
   localparam logic [CYC_W-1:0] TWO  = CYC_W'(2);

   logic [CYC_W-1:0] idx_q, ncyc_q, ncyc_eff;
   attr_t            attr_q;
   logic             capture;

   assign capture = (slot_i == SL_FETCH_A) && (idx_q == '0);

   always_comb begin
      if (xdata_i)          ncyc_eff = TWO;
      else if (cyc_i == '0) ncyc_eff = ONE;
      else if (cyc_i > CMAX) ncyc_eff = CMAX;
      else                  ncyc_eff = cyc_i;
   end

   assign last_o = (idx_q == ncyc_q - ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q  <= '0;
         ncyc_q <= ONE;
         attr_q <= '0;
      end else begin
         if (capture) begin
            ncyc_q      <= ncyc_eff;
            attr_q.len2  <= len2_i & ~xdata_i;
            attr_q.xdata <= xdata_i;
         end
         if (wrap_i) idx_q <= last_o ? '0 : idx_q + ONE;
      end
   end

   assign cyc_idx_o = idx_q;
   assign attr_o    = attr_q;
endmodule

// File: rtl/mcyc_strobe_dec.sv
module mcyc_strobe_dec
   import mcyc_pkg::*;
#(
   parameter int CYC_W = 3
) (
   input  slot_t            slot_i,
   input  logic [CYC_W-1:0] cyc_idx_i,
   input  attr_t            attr_i,
   input  logic             last_i,
   output logic             ale_o,
   output logic             opc_o,
   output logic             opr_o,
   output logic             disc_o,
   output logic             pcinc_o,
   output logic             xstb_o,
   output logic             eoi_o
);
   logic first, skip, at_a, at_b, in_win;

   assign first  = (cyc_idx_i == '0);
   assign skip   = attr_i.xdata && (cyc_idx_i == CYC_W'(1));
   assign at_a   = (slot_i == SL_FETCH_A);
   assign at_b   = (slot_i == SL_FETCH_B);
   assign in_win = at_a || at_b || (slot_i == SL_ALE_A2) || (slot_i == SL_ALE_B2);

   assign ale_o   = in_win && !skip;
   assign opc_o   = at_a && first;
   assign opr_o   = at_b && first && attr_i.len2;
   assign disc_o  = !skip && ((at_a && !first) || (at_b && !(first && attr_i.len2)));
   assign pcinc_o = opc_o || opr_o;
   assign xstb_o  = skip;
   assign eoi_o   = last_i && (slot_i == SL_LAST);
endmodule

// File: rtl/mcyc_fetch_seq.sv
module mcyc_fetch_seq
   import mcyc_pkg::*;
#(
   parameter int MAX_CYC     = 4,
   parameter int CYC_W       = 3,
   parameter bit ONEHOT_SLOT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ins_len2_i,
   input  logic [CYC_W-1:0] ins_cyc_i,
   input  logic             ins_xdata_i,
   output logic [2:0]       state_o,
   output logic             phase_o,
   output logic             ale_o,
   output logic             opc_latch_o,
   output logic             opr_latch_o,
   output logic             discard_o,
   output logic             pc_inc_o,
   output logic             xdata_stb_o,
   output logic             eoi_o
);
   initial begin
      if (MAX_CYC < 2)
         $error("MAX_CYC must allow the two-cycle data move");
      if (MAX_CYC >= (1 << CYC_W))
         $error("CYC_W too narrow for MAX_CYC");
      if (ST_W != 3)
         $error("state output width mismatch");
   end

   slot_t            slot;
   logic             wrap, last;
   logic [CYC_W-1:0] cyc_idx;
   attr_t            attr;

   mcyc_slot_ctr #(.ONEHOT(ONEHOT_SLOT)) slot_i (
      .clk(clk), .rst(rst), .slot_o(slot), .wrap_o(wrap)
   );

   mcyc_cyc_track #(.MAX_CYC(MAX_CYC), .CYC_W(CYC_W)) trk_i (
      .clk(clk), .rst(rst), .slot_i(slot), .wrap_i(wrap),
      .len2_i(ins_len2_i), .cyc_i(ins_cyc_i), .xdata_i(ins_xdata_i),
      .cyc_idx_o(cyc_idx), .attr_o(attr), .last_o(last)
   );

   mcyc_strobe_dec #(.CYC_W(CYC_W)) dec_i (
      .slot_i(slot), .cyc_idx_i(cyc_idx), .attr_i(attr), .last_i(last),
      .ale_o(ale_o), .opc_o(opc_latch_o), .opr_o(opr_latch_o),
      .disc_o(discard_o), .pcinc_o(pc_inc_o), .xstb_o(xdata_stb_o),
      .eoi_o(eoi_o)
   );

   assign state_o = slot[SLOT_W-1:1];
   assign phase_o = slot[0];
endmodule

// File: rtl/mcyc_fetch_seq_chk.sv
module mcyc_fetch_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic [2:0] state_o,
   input logic       phase_o,
   input logic       ale_o,
   input logic       opc_latch_o,
   input logic       opr_latch_o,
   input logic       discard_o,
   input logic       pc_inc_o,
   input logic       xdata_stb_o,
   input logic       eoi_o
);
   assert_phase_alt_R1: assert property (@(posedge clk) disable iff (rst)
      !rst |=> phase_o != $past(phase_o));
   assert_state_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (state_o == 3'd5 && phase_o) |=> (state_o == 3'd0 && !phase_o));
   assert_ale_rise_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(ale_o) |-> phase_o);
   assert_ale_pair_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(ale_o) |=> ale_o);
   assert_pcinc_src_R3: assert property (@(posedge clk) disable iff (rst)
      pc_inc_o |-> (opc_latch_o || opr_latch_o));
   assert_disc_nopc_R5: assert property (@(posedge clk) disable iff (rst)
      discard_o |-> !pc_inc_o);
   assert_fetch_excl_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0({opc_latch_o, opr_latch_o, discard_o}));
   assert_eoi_slot_R6: assert property (@(posedge clk) disable iff (rst)
      eoi_o |-> (state_o == 3'd5 && phase_o));
   assert_eoi_next_R6: assert property (@(posedge clk) disable iff (rst)
      eoi_o |=> ##1 opc_latch_o);
   assert_xstb_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      xdata_stb_o |-> !(ale_o || opc_latch_o || opr_latch_o || discard_o));
   assert_xstb_start_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(xdata_stb_o) |-> (state_o == 3'd0 && !phase_o));
   assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_o == 3'd0 && !phase_o && !ale_o && !xdata_stb_o));
endmodule

bind mcyc_fetch_seq mcyc_fetch_seq_chk chk_i (
   .clk(clk), .rst(rst), .state_o(state_o), .phase_o(phase_o),
   .ale_o(ale_o), .opc_latch_o(opc_latch_o), .opr_latch_o(opr_latch_o),
   .discard_o(discard_o), .pc_inc_o(pc_inc_o), .xdata_stb_o(xdata_stb_o),
   .eoi_o(eoi_o)
);

// File: tb/mcyc_fetch_seq_tb_top.sv
module mcyc_fetch_seq_tb_top;
   localparam int CW = 3;
   localparam int MC = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          len2 = 1'b0;
   logic [CW-1:0] cyc = '0;
   logic          xd = 1'b0;
   logic [2:0]    state_o;
   logic          phase_o, ale_o, opc_o, opr_o, disc_o, pcinc_o, xstb_o, eoi_o;
   int            n_vec = 0;
   int            n_bad = 0;
   bit            done  = 1'b0;

   always #10 clk = ~clk;

   mcyc_fetch_seq #(.MAX_CYC(MC), .CYC_W(CW)) dut_i (
      .clk(clk), .rst(rst), .ins_len2_i(len2), .ins_cyc_i(cyc),
      .ins_xdata_i(xd), .state_o(state_o), .phase_o(phase_o),
      .ale_o(ale_o), .opc_latch_o(opc_o), .opr_latch_o(opr_o),
      .discard_o(disc_o), .pc_inc_o(pcinc_o), .xdata_stb_o(xstb_o),
      .eoi_o(eoi_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk_reset();
      chk("R10", "state", int'(state_o), 0);
      chk("R10", "phase", int'(phase_o), 0);
      chk("R10", "strobes",
          int'({ale_o, opc_o, opr_o, disc_o, pcinc_o, xstb_o, eoi_o}), 0);
   endtask

   // t = oscillator period since instruction start
   task automatic chk_slot(input int l2, input int ec, input int x, input int t);
      int c, s, p, el, ncy;
      bit skip, a, b;
      c = t / 12; s = (t % 12) / 2; p = t % 2;
      el = x ? 0 : l2;
      ncy = x ? 2 : ec;
      skip = (x != 0) && (c == 1);
      a = (s == 0 && p == 1);
      b = (s == 3 && p == 1);
      chk("R1", "state", int'(state_o), s);
      chk("R1", "phase", int'(phase_o), p);
      chk("R2", "ale", int'(ale_o),
          int'(!skip && (a || b || (s == 1 && p == 0) || (s == 4 && p == 0))));
      chk("R3", "opc_latch", int'(opc_o), int'(a && c == 0));
      chk("R4", "opr_latch", int'(opr_o), int'(b && c == 0 && el == 1));
      chk("R5_R7", "discard", int'(disc_o),
          int'(!skip && ((a && c != 0) || (b && !(c == 0 && el == 1)))));
      chk("R3_R4", "pc_inc", int'(pcinc_o), int'(c == 0 && (a || (b && el == 1))));
      chk("R8", "xdata_stb", int'(xstb_o), int'(skip));
      chk("R6", "eoi", int'(eoi_o), int'(c == ncy - 1 && s == 5 && p == 1));
   endtask

   // entered at a falling edge with the design at period 0 of an instruction
   task automatic run_insn(input int l2, input int cy, input int x, input int abort_at);
      int ec, total;
      ec = (cy == 0) ? 1 : ((cy > MC) ? MC : cy);
      total = 12 * (x ? 2 : ec);
      len2 = l2[0]; cyc = CW'(cy); xd = x[0];
      for (int t = 0; t < total; t++) begin
         if (t > 0) @(negedge clk);
         chk_slot(l2, ec, x, t);
         if (t == 2) begin // R9: scramble attributes after the capture edge
            len2 = ~len2; cyc = ~cyc; xd = ~xd;
         end
         if (t == abort_at) begin
            rst = 1'b1;
            @(negedge clk);
            chk_reset();
            rst = 1'b0;
            return;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_reset();
      rst = 1'b0;
      for (int x = 0; x < 2; x++)
         for (int l = 0; l < 2; l++)
            for (int cy = 0; cy < (1 << CW); cy++)
               run_insn(l, cy, x, -1);
      run_insn(1, 1, 1, 15); // R10: reset during data-move second cycle
      run_insn(0, 1, 0, -1);
      run_insn(1, 4, 0, 30); // R10: reset during a later cycle
      run_insn(1, 2, 0, -1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule